// File: doc/BRIEF.md
# PWM Interrupt and Output Conditioner

This block sits next to a four-channel PWM timer core. Each channel's reload event arrives as a strobe at the start of every new PWM cycle, when that channel's period and width shadow values are taken over. Each strobe sets a per-channel flag that software can read. When enabled, the strobe also sets one shared module flag, which drives the CPU interrupt request. Software clears the channel flags itself by writing ones to a clear register. The CPU's acknowledge strobe clears the module flag, and a later enabled event sets it again.

On the output side, each raw PWM level is ANDed with a per-channel output enable and then XORed with a per-channel polarity bit before it drives the pin. A small write-only register port loads the enables and polarity bits and clears the flags. The flags can be read directly on an output bus.

Top module: `pwm_irq_outctl`

## Requirements
- R1: After reset all channel flags, the interrupt request, all enables and all polarity bits are 0, so `flagQ`, `irqReq` and `pinOut` all read 0.
- R2: A 1 on `reloadEv[i]` sets `flagQ[i]` after the next rising clock edge, whatever the interrupt enables hold.
- R3: A channel flag stays set until a write to address 0 carries a 1 in bit i of `regWrData`. Zero bits of that write, writes to other addresses and `irqAck` leave the flags unchanged.
- R4: If a clear of flag i and a reload event on channel i fall in the same cycle, flag i stays set.
- R5: `irqReq` rises after the edge that samples a reload event on a channel i whose interrupt enable is 1 and while the module enable is 1. The channel interrupt enables are written at address 1, bits [3:0]. The module enable is written at address 2, bit 0.
- R6: `irqAck` clears `irqReq` after the next edge, however many channel flags are set. Otherwise `irqReq` holds its value.
- R7: If an enabled event and `irqAck` occur in the same cycle, `irqReq` stays 1.
- R8: `pinOut[i]` equals `(pwmIn[i] AND outEn[i]) XOR pol[i]`, with no clock delay. The output enables are written at address 3, bits [3:0]. The polarity bits are written at address 4, bits [3:0].
- R9: Writes to addresses 5, 6 and 7 change no state.
- R10: A reload event on a channel whose interrupt enable is 0, or any event while the module enable is 0, sets only the channel flag and leaves `irqReq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reloadEv | input | 4 | Per-channel reload (new PWM cycle) strobes |
| pwmIn | input | 4 | Raw PWM levels from the timer core |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 4 | Register write data |
| irqAck | input | 1 | Interrupt acknowledge strobe |
| irqReq | output | 1 | Module interrupt request (registered module flag) |
| flagQ | output | 4 | Channel flags, readable |
| pinOut | output | 4 | Conditioned pin drive levels |

## Verification
The assertions assume only synchronous inputs and a reset held at the start. They allow any pattern of reload, acknowledge and write, including events, clears and acknowledges that all fall in the same cycle. The assertions therefore hold for any pattern of inputs. The directed stimulus builds each collision on purpose: a clear together with a reload, an acknowledge together with an enabled event, and writes to unused addresses. A long random phase then draws every input, addresses included, from the full range, with acknowledges kept sparse so that the request has time to build up.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;
  parameter int unsigned PWM_CH = 4;
  parameter int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = PWM_CH;

  localparam logic [REG_AW-1:0] ADR_FLAGCLR = 3'd0;
  localparam logic [REG_AW-1:0] ADR_CHIE    = 3'd1;
  localparam logic [REG_AW-1:0] ADR_MODEN   = 3'd2;
  localparam logic [REG_AW-1:0] ADR_OUTEN   = 3'd3;
  localparam logic [REG_AW-1:0] ADR_POL     = 3'd4;

  typedef struct packed {
    logic [PWM_CH-1:0] flagClr;
    logic              ldChIe;
    logic              ldModEn;
    logic              ldOutEn;
    logic              ldPol;
    logic [REG_DW-1:0] wrBits;
    logic              modSet;
    logic              modClr;
  } ctlStrobes_t;
endpackage

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl
  import pwm_irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic [PWM_CH-1:0] reloadEv,
  input  logic [PWM_CH-1:0] chIe,
  input  logic              modEn,
  input  logic              irqAck,
  output ctlStrobes_t       strb
);
  logic [PWM_CH-1:0] qualEv;

  always_comb begin
    strb         = '0;
    strb.wrBits  = regWrData;
    if (regWrEn) begin
      case (regAddr)
        ADR_FLAGCLR: strb.flagClr = regWrData[PWM_CH-1:0];
        ADR_CHIE:    strb.ldChIe  = 1'b1;
        ADR_MODEN:   strb.ldModEn = 1'b1;
        ADR_OUTEN:   strb.ldOutEn = 1'b1;
        ADR_POL:     strb.ldPol   = 1'b1;
        default:     strb.ldPol   = 1'b0;
      endcase
    end
    qualEv      = reloadEv & chIe;
    strb.modSet = modEn && (qualEv != '0);
    strb.modClr = irqAck;
  end
endmodule

// File: rtl/pwm_irq_dp.sv
module pwm_irq_dp
  import pwm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [PWM_CH-1:0] reloadEv,
  input  logic [PWM_CH-1:0] pwmIn,
  output logic [PWM_CH-1:0] chFlagQ,
  output logic [PWM_CH-1:0] chIeQ,
  output logic              modEnQ,
  output logic [PWM_CH-1:0] outEnQ,
  output logic [PWM_CH-1:0] polQ,
  output logic              modFlagQ,
  output logic [PWM_CH-1:0] pinOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chIeQ  <= '0;
      modEnQ <= 1'b0;
      outEnQ <= '0;
      polQ   <= '0;
    end else begin
      if (strb.ldChIe)  chIeQ  <= strb.wrBits[PWM_CH-1:0];
      if (strb.ldModEn) modEnQ <= strb.wrBits[0];
      if (strb.ldOutEn) outEnQ <= strb.wrBits[PWM_CH-1:0];
      if (strb.ldPol)   polQ   <= strb.wrBits[PWM_CH-1:0];
    end
  end

  // set wins over clear for module flag
  always_ff @(posedge clk) begin
    if (!rstN)            modFlagQ <= 1'b0;
    else if (strb.modSet) modFlagQ <= 1'b1;
    else if (strb.modClr) modFlagQ <= 1'b0;
  end

  for (genvar ch = 0; ch < PWM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                 chFlagQ[ch] <= 1'b0;
      else if (reloadEv[ch])     chFlagQ[ch] <= 1'b1;
      else if (strb.flagClr[ch]) chFlagQ[ch] <= 1'b0;
    end
    assign pinOut[ch] = (pwmIn[ch] & outEnQ[ch]) ^ polQ[ch];
  end
endmodule

// File: rtl/pwm_irq_outctl.sv
module pwm_irq_outctl
  import pwm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PWM_CH-1:0] reloadEv,
  input  logic [PWM_CH-1:0] pwmIn,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [PWM_CH-1:0] flagQ,
  output logic [PWM_CH-1:0] pinOut
);
  ctlStrobes_t       strb;
  logic [PWM_CH-1:0] chIeQ;
  logic              modEnQ;
  logic [PWM_CH-1:0] outEnQ;
  logic [PWM_CH-1:0] polQ;
  logic              modFlagQ;

  pwm_irq_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .reloadEv (reloadEv),
    .chIe     (chIeQ),
    .modEn    (modEnQ),
    .irqAck   (irqAck),
    .strb     (strb)
  );

  pwm_irq_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reloadEv(reloadEv),
    .pwmIn   (pwmIn),
    .chFlagQ (flagQ),
    .chIeQ   (chIeQ),
    .modEnQ  (modEnQ),
    .outEnQ  (outEnQ),
    .polQ    (polQ),
    .modFlagQ(modFlagQ),
    .pinOut  (pinOut)
  );

  assign irqReq = modFlagQ;
endmodule

// File: rtl/pwm_irq_chk.sv
module pwm_irq_chk
  import pwm_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [PWM_CH-1:0] reloadEv,
  input logic              irqAck,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [PWM_CH-1:0] flagQ,
  input logic              irqReq,
  input logic [PWM_CH-1:0] pinOut,
  input logic [PWM_CH-1:0] chIe,
  input logic              modEn,
  input logic [PWM_CH-1:0] outEn,
  input logic [PWM_CH-1:0] pol
);
  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reloadEv != '0) |=> ((flagQ & $past(reloadEv)) == $past(reloadEv)));

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADR_FLAGCLR) |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && ((reloadEv & chIe) != '0)) |=> irqReq);

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !(modEn && ((reloadEv & chIe) != '0))) |=> !irqReq);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && (!modEn || ((reloadEv & chIe) == '0))) |=> !irqReq);

  p_pin_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outEn == '0) |-> (pinOut == pol));
endmodule

bind pwm_irq_outctl pwm_irq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reloadEv(reloadEv),
  .irqAck  (irqAck),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .flagQ   (flagQ),
  .irqReq  (irqReq),
  .pinOut  (pinOut),
  .chIe    (chIeQ),
  .modEn   (modEnQ),
  .outEn   (outEnQ),
  .pol     (polQ)
);

// File: tb/pwm_irq_outctl_tb.sv
module pwm_irq_outctl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reloadEv = '0;
  logic [3:0] pwmIn = '0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [3:0] regWrData = '0;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic [3:0] flagQ;
  logic [3:0] pinOut;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  bit [3:0] mFlag, mChIe, mOutEn, mPol;
  bit       mModEn, mIrq;

  always #5 clk = ~clk;

  pwm_irq_outctl dut_i (
    .clk(clk), .rstN(rstN), .reloadEv(reloadEv), .pwmIn(pwmIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .irqAck(irqAck), .irqReq(irqReq), .flagQ(flagQ), .pinOut(pinOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mFlag <= '0; mChIe <= '0; mOutEn <= '0; mPol <= '0;
      mModEn <= 1'b0; mIrq <= 1'b0;
    end else begin
      bit [3:0] clrBits;
      bit       hit;
      clrBits = (regWrEn && regAddr == 3'd0) ? regWrData : 4'h0;
      hit = 1'b0;
      for (int i = 0; i < 4; i++)
        if (reloadEv[i] && mChIe[i] && mModEn) hit = 1'b1;
      for (int i = 0; i < 4; i++)
        mFlag[i] <= reloadEv[i] ? 1'b1 : (clrBits[i] ? 1'b0 : mFlag[i]);
      if (hit) mIrq <= 1'b1;
      else if (irqAck) mIrq <= 1'b0;
      if (regWrEn) begin
        if (regAddr == 3'd1) mChIe  <= regWrData;
        if (regAddr == 3'd2) mModEn <= regWrData[0];
        if (regAddr == 3'd3) mOutEn <= regWrData;
        if (regAddr == 3'd4) mPol   <= regWrData;
      end
    end
  end

  task automatic compare();
    bit [3:0] expPin;
    for (int i = 0; i < 4; i++)
      expPin[i] = mPol[i] ? !(pwmIn[i] && mOutEn[i]) : (pwmIn[i] && mOutEn[i]);
    vectors++;
    if (flagQ !== mFlag) begin
      miscompares++;
      $display("FAIL %s flagQ actual %h expected %h", curReq, flagQ, mFlag);
    end
    if (irqReq !== mIrq) begin
      miscompares++;
      $display("FAIL %s irqReq actual %b expected %b", curReq, irqReq, mIrq);
    end
    if (pinOut !== expPin) begin
      miscompares++;
      $display("FAIL %s pinOut actual %h expected %h", curReq, pinOut, expPin);
    end
  endtask

  task automatic cyc(input bit [3:0] rl, input bit [3:0] pw, input bit we,
                     input bit [2:0] ad, input bit [3:0] wd, input bit ak);
    reloadEv = rl; pwmIn = pw; regWrEn = we; regAddr = ad;
    regWrData = wd; irqAck = ak;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input bit [2:0] ad, input bit [3:0] wd);
    cyc(4'h0, pwmIn, 1'b1, ad, wd, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL %s watchdog actual running expected finished", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; compare();
    cyc(4'h0, 4'hF, 1'b0, 3'd0, 4'h0, 1'b0);      // R1 pins low, no enables

    curReq = "R2"; cyc(4'h2, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0); // flag, no irq
    curReq = "R10"; cyc(4'h0, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0);
    wr(3'd1, 4'h5);                                 // chIe = 0101, modEn off
    cyc(4'h1, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0);        // R10 module disabled
    wr(3'd2, 4'h1);
    cyc(4'hA, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0);        // R10 disabled chans only

    curReq = "R5"; cyc(4'h1, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0);
    cyc(4'h0, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0);
    curReq = "R6"; cyc(4'h0, 4'h0, 1'b0, 3'd0, 4'h0, 1'b1);
    curReq = "R3"; cyc(4'h0, 4'h0, 1'b0, 3'd0, 4'h0, 1'b1);
    wr(3'd0, 4'h0);
    wr(3'd0, 4'h2);
    curReq = "R4"; cyc(4'h1, 4'h0, 1'b1, 3'd0, 4'h1, 1'b0);
    curReq = "R7"; cyc(4'h4, 4'h0, 1'b0, 3'd0, 4'h0, 1'b1);
    cyc(4'h0, 4'h0, 1'b0, 3'd0, 4'h0, 1'b0);

    curReq = "R8";
    wr(3'd3, 4'hF);
    cyc(4'h0, 4'h6, 1'b0, 3'd0, 4'h0, 1'b0);
    wr(3'd4, 4'h9);
    cyc(4'h0, 4'h3, 1'b0, 3'd0, 4'h0, 1'b0);
    wr(3'd3, 4'h5);
    cyc(4'h0, 4'hF, 1'b0, 3'd0, 4'h0, 1'b0);

    curReq = "R9";
    wr(3'd5, 4'hF); wr(3'd6, 4'hF); wr(3'd7, 4'hF);
    cyc(4'h0, 4'hA, 1'b0, 3'd0, 4'h0, 1'b1);
    cyc(4'hF, 4'h5, 1'b0, 3'd0, 4'h0, 1'b0);

    curReq = "R5";
    for (int k = 0; k < 600; k++)
      cyc(4'($urandom), 4'($urandom), 1'($urandom), 3'($urandom),
          4'($urandom), ($urandom % 5) == 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule